// File: doc/BRIEF.md
# Call, Return and Interrupt Stack Sequencer

This block runs the stack-side work of subroutine calls, subroutine returns and hardware interrupt service for a 16-bit processor with word-addressed memory. The stack grows toward lower addresses one word at a time, and every push decrements the stack pointer before it writes. The surrounding core supplies the architectural PC, stack pointer and status flags. It issues a call or return command, or marks an instruction boundary at which an interrupt may be taken. The block performs the memory reads and writes and then hands back new PC, stack pointer and flag values as single-cycle write strobes.

A call finds its destination in the memory word that follows the call instruction, so the current PC points at that word. The saved return address is the word after it. An interrupt saves the flags first and the PC second, then continues at a fixed vector. There is no return instruction for an interrupt. When the request line falls at a later instruction boundary, the block pops the PC and then the flags, which is the reverse of the push order. Only one interrupt can be active at a time.

Top module: `subr_stack_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, the block is idle: no memory request, no register write strobe, done low, interrupt-active low.
- R2: A call command (start_i high with op_ret_i = 0) reads the word at PC and then writes PC+1 at SP-1. It then finishes with PC set to the word it read and SP set to SP-1.
- R3: A return command (start_i high with op_ret_i = 1) reads the word at SP, then finishes with PC set to that word and SP set to SP+1.
- R4: Interrupt entry writes the flags, zero-extended into bits FW-1:0 of the word, at SP-1, then writes PC at SP-2. It finishes with PC set to the vector, SP set to SP-2 and interrupt-active high.
- R5: An interrupt request, and the exit from an active interrupt, are acted on only in a cycle where boundary_i is high and the block is idle. While boundary_i is low they have no effect.
- R6: While an interrupt is active, a high request line starts no new entry, and SP and memory are left untouched.
- R7: Interrupt exit occurs when the block is idle, interrupt-active is high, boundary_i is high and irq_i is low. It reads PC from SP and then flags from SP+1. It finishes with SP set to SP+2, writes back the PC and flags it read, and clears interrupt-active.
- R8: Each memory access holds mem_req_o, its address, direction and write data stable until mem_ready_i is high. The access completes in the cycle in which both are high.
- R9: done_o is high for exactly one cycle, together with the register write strobes, in the cycle after the last access completes. Counted from the clock edge that accepts a sequence, done appears after (number of accesses + 1 + wait cycles) edges.
- R10: A command is accepted only while idle. A start_i held during a running sequence is ignored. A command present in an idle cycle is taken ahead of an interrupt entry or exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Command strobe, sampled while idle |
| op_ret_i | input | 1 | Command kind: 0 call, 1 return |
| irq_i | input | 1 | Interrupt request level |
| boundary_i | input | 1 | High at an instruction boundary |
| pc_i | input | DW | Current PC |
| sp_i | input | DW | Current stack pointer |
| flags_i | input | FW | Current status flags |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access direction, 1 = write |
| mem_addr_o | output | DW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access completes when high with the request |
| pc_we_o | output | 1 | PC write strobe |
| pc_wdata_o | output | DW | New PC |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | DW | New stack pointer |
| flg_we_o | output | 1 | Flag write strobe |
| flg_wdata_o | output | FW | New flags |
| busy_o | output | 1 | A sequence is running |
| isr_active_o | output | 1 | An interrupt is being serviced |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A sequence with k memory accesses raises done after k+1 edges plus one edge for each cycle in which the request waited on ready. The bench counts the edges from the accepting edge and the stalls it imposes, then compares the observed count with that figure. Calls and interrupt transitions use two accesses and returns use one. The register writes land on the edge that ends the done cycle, so the bench checks PC, SP, flags and memory one cycle after done. Gating, no-nesting and ignored-start checks watch busy and done over a fixed window of cycles and then compare SP and the vector state at the ports.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_JTGT, ST_JPUSH, ST_RPOP,
    ST_IFLG, ST_IPC, ST_XPC, ST_XFLG, ST_FIN
  } stk_state_e;

  typedef enum logic [1:0] {K_CALL, K_RET, K_ENTER, K_EXIT} stk_kind_e;
endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       op_ret_i,
  input  logic       irq_i,
  input  logic       boundary_i,
  input  logic       mem_ready_i,
  output stk_state_e st_o,
  output stk_kind_e  kind_o,
  output logic       launch_o,
  output logic       isr_o
);
  stk_state_e st_q, st_nx;
  stk_kind_e  kind_q, kind_nx;
  logic       isr_q, isr_nx, isr_en;

  // next-state logic
  always_comb begin
    st_nx   = st_q;
    kind_nx = kind_q;
    isr_nx  = isr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          kind_nx = op_ret_i ? K_RET : K_CALL;
          st_nx   = op_ret_i ? ST_RPOP : ST_JTGT;
        end else if (boundary_i && irq_i && !isr_q) begin
          kind_nx = K_ENTER;
          st_nx   = ST_IFLG;
        end else if (boundary_i && !irq_i && isr_q) begin
          kind_nx = K_EXIT;
          st_nx   = ST_XPC;
        end
      end
      ST_JTGT:  if (mem_ready_i) st_nx = ST_JPUSH;
      ST_JPUSH: if (mem_ready_i) st_nx = ST_FIN;
      ST_RPOP:  if (mem_ready_i) st_nx = ST_FIN;
      ST_IFLG:  if (mem_ready_i) st_nx = ST_IPC;
      ST_IPC:   if (mem_ready_i) st_nx = ST_FIN;
      ST_XPC:   if (mem_ready_i) st_nx = ST_XFLG;
      ST_XFLG:  if (mem_ready_i) st_nx = ST_FIN;
      ST_FIN: begin
        st_nx = ST_IDLE;
        if (kind_q == K_ENTER) isr_nx = 1'b1;
        if (kind_q == K_EXIT)  isr_nx = 1'b0;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign launch_o = (st_q == ST_IDLE) && (st_nx != ST_IDLE);
  assign isr_en   = (st_q == ST_FIN);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_CALL;
      isr_q  <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (launch_o) kind_q <= kind_nx;
      if (isr_en)   isr_q  <= isr_nx;
    end
  end

  assign st_o   = st_q;
  assign kind_o = kind_q;
  assign isr_o  = isr_q;

  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IFLG) |-> !isr_q); // R6
  AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_IFLG || st_q == ST_XPC) |-> $past(boundary_i)); // R5
endmodule

// File: rtl/stk_path.sv
module stk_path
  import stk_pkg::*;
#(
  parameter int              DW  = 16,
  parameter int              FW  = 5,
  parameter logic [DW-1:0]   VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_state_e    st_i,
  input  stk_kind_e     kind_i,
  input  logic          launch_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [FW-1:0] flags_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_wdata_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_wdata_o,
  output logic          flg_we_o,
  output logic [FW-1:0] flg_wdata_o,
  output logic          done_o
);
  localparam int            PADW = DW - FW;
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] TWO  = DW'(2);

  logic [DW-1:0] wsp_q, wpc_q, wtgt_q;
  logic [FW-1:0] wflg_q, flg_nx;
  logic          rd_done, tgt_en, flg_en, fin;

  // access decode
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = wsp_q;
    mem_wdata_o = wpc_q;
    unique case (st_i)
      ST_JTGT:  begin mem_req_o = 1'b1; mem_addr_o = wpc_q; end
      ST_JPUSH: begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = wsp_q - ONE; mem_wdata_o = wpc_q + ONE; end
      ST_RPOP:  begin mem_req_o = 1'b1; mem_addr_o = wsp_q; end
      ST_IFLG:  begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = wsp_q - ONE; mem_wdata_o = {{PADW{1'b0}}, wflg_q}; end
      ST_IPC:   begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = wsp_q - TWO; mem_wdata_o = wpc_q; end
      ST_XPC:   begin mem_req_o = 1'b1; mem_addr_o = wsp_q; end
      ST_XFLG:  begin mem_req_o = 1'b1; mem_addr_o = wsp_q + ONE; end
      default: ;
    endcase
  end

  assign rd_done = mem_req_o && mem_ready_i && !mem_we_o;
  assign tgt_en  = rd_done && (st_i != ST_XFLG);
  assign flg_en  = launch_i || (rd_done && (st_i == ST_XFLG));
  assign flg_nx  = launch_i ? flags_i : mem_rdata_i[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsp_q  <= '0;
      wpc_q  <= '0;
      wtgt_q <= '0;
      wflg_q <= '0;
    end else begin
      if (launch_i) begin
        wsp_q <= sp_i;
        wpc_q <= pc_i;
      end
      if (tgt_en) wtgt_q <= mem_rdata_i;
      if (flg_en) wflg_q <= flg_nx;
    end
  end

  // completion writes
  assign fin         = (st_i == ST_FIN);
  assign done_o      = fin;
  assign pc_we_o     = fin;
  assign sp_we_o     = fin;
  assign flg_we_o    = fin && (kind_i == K_EXIT);
  assign pc_wdata_o  = (kind_i == K_ENTER) ? VEC : wtgt_q;
  assign flg_wdata_o = wflg_q;

  always_comb begin
    unique case (kind_i)
      K_CALL:  sp_wdata_o = wsp_q - ONE;
      K_RET:   sp_wdata_o = wsp_q + ONE;
      K_ENTER: sp_wdata_o = wsp_q - TWO;
      default: sp_wdata_o = wsp_q + TWO;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
endmodule

// File: rtl/subr_stack_seq.sv
module subr_stack_seq
  import stk_pkg::*;
#(
  parameter int            DW  = 16,
  parameter int            FW  = 5,
  parameter logic [DW-1:0] VEC = '0
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start_i,
  input  logic          op_ret_i,
  input  logic          irq_i,
  input  logic          boundary_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [FW-1:0] flags_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_wdata_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_wdata_o,
  output logic          flg_we_o,
  output logic [FW-1:0] flg_wdata_o,
  output logic          busy_o,
  output logic          isr_active_o,
  output logic          done_o
);
  logic       rst_n, launch;
  stk_state_e st;
  stk_kind_e  kind;

  stk_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  stk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_ret_i(op_ret_i),
    .irq_i(irq_i), .boundary_i(boundary_i), .mem_ready_i(mem_ready_i),
    .st_o(st), .kind_o(kind), .launch_o(launch), .isr_o(isr_active_o)
  );

  stk_path #(.DW(DW), .FW(FW), .VEC(VEC)) u_path (
    .clk(clk), .rst_n(rst_n), .st_i(st), .kind_i(kind), .launch_i(launch),
    .pc_i(pc_i), .sp_i(sp_i), .flags_i(flags_i),
    .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o), .flg_we_o(flg_we_o),
    .flg_wdata_o(flg_wdata_o), .done_o(done_o)
  );

  assign busy_o = (st != ST_IDLE);

  AST_CALL_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we_o && kind == K_CALL) |-> (sp_wdata_o + DW'(1) == sp_i)); // R2
  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind == K_ENTER) |=> isr_active_o); // R4
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind == K_EXIT) |=> !isr_active_o); // R7
endmodule

// File: tb/sim_subr_stack_seq.sv
`timescale 1ns/1ps
module sim_subr_stack_seq;
  localparam int DW = 16;
  localparam int FW = 5;
  localparam logic [DW-1:0] VEC = 16'h0000;

  logic clk = 1'b0;
  logic arst_n;
  logic start_i, op_ret_i, irq_i, boundary_i, mem_ready_i;
  logic [DW-1:0] arch_pc, arch_sp;
  logic [FW-1:0] arch_flg;
  logic mem_req_o, mem_we_o, pc_we_o, sp_we_o, flg_we_o, busy_o, isr_active_o, done_o;
  logic [DW-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i, pc_wdata_o, sp_wdata_o;
  logic [FW-1:0] flg_wdata_o;
  logic [DW-1:0] mem [256];
  logic rdy_mode;
  int checks = 0, errors = 0, waits = 0, dn_cnt = 0;

  always #2.5 clk = ~clk;

  subr_stack_seq #(.DW(DW), .FW(FW), .VEC(VEC)) u0 (
    .clk(clk), .arst_n(arst_n), .start_i(start_i), .op_ret_i(op_ret_i),
    .irq_i(irq_i), .boundary_i(boundary_i), .pc_i(arch_pc), .sp_i(arch_sp),
    .flags_i(arch_flg), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o), .flg_we_o(flg_we_o),
    .flg_wdata_o(flg_wdata_o), .busy_o(busy_o), .isr_active_o(isr_active_o),
    .done_o(done_o)
  );

  assign mem_rdata_i = mem[mem_addr_o[7:0]];

  always @(posedge clk) begin
    if (mem_req_o && mem_ready_i && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_req_o && !mem_ready_i) waits <= waits + 1;
    if (done_o) dn_cnt <= dn_cnt + 1;
    if (pc_we_o) arch_pc <= pc_wdata_o;
    if (sp_we_o) arch_sp <= sp_wdata_o;
    if (flg_we_o) arch_flg <= flg_wdata_o;
  end

  always @(negedge clk) mem_ready_i <= rdy_mode ? (($urandom % 3) != 0) : 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Launch at the next edge; returns edges until done was seen, plus one settle cycle.
  task automatic go(input logic is_cmd, input logic ret, input logic hold, output int n);
    waits = 0;
    if (is_cmd) begin start_i = 1'b1; op_ret_i = ret; end
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (hold && !done_o) op_ret_i = ~ret; else start_i = 1'b0;
    end while (!done_o && n < 300);
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int lat(input int acc, input int w);
    return acc + 1 + w;
  endfunction

  task automatic do_call(input logic [DW-1:0] pc, input logic [DW-1:0] sp,
                         input logic [DW-1:0] tgt, input logic hold);
    int n, d0;
    arch_pc = pc; arch_sp = sp; mem[pc[7:0]] = tgt; d0 = dn_cnt;
    go(1'b1, 1'b0, hold, n);
    chk("R9 call latency", n, lat(2, waits));
    chk("R2 call pc", arch_pc, tgt);
    chk("R2 call sp", arch_sp, sp - 1);
    chk("R2 call pushed word", mem[(sp - 16'd1) & 16'hFF], pc + 16'd1);
    chk("R10 one done per call", dn_cnt - d0, 1);
  endtask

  task automatic do_ret(input logic [DW-1:0] sp, input logic [DW-1:0] word);
    int n;
    arch_sp = sp; mem[sp[7:0]] = word;
    go(1'b1, 1'b1, 1'b0, n);
    chk("R9 return latency", n, lat(1, waits));
    chk("R3 return pc", arch_pc, word);
    chk("R3 return sp", arch_sp, sp + 1);
  endtask

  task automatic do_irq(input logic [DW-1:0] pc, input logic [DW-1:0] sp, input logic [FW-1:0] fl);
    int n;
    arch_pc = pc; arch_sp = sp; arch_flg = fl;
    irq_i = 1'b1; boundary_i = 1'b1;
    go(1'b0, 1'b0, 1'b0, n);
    chk("R9 entry latency", n, lat(2, waits));
    chk("R4 entry pc", arch_pc, VEC);
    chk("R4 entry sp", arch_sp, sp - 2);
    chk("R4 flags word", mem[(sp - 16'd1) & 16'hFF], {11'd0, fl});
    chk("R4 pc word", mem[(sp - 16'd2) & 16'hFF], pc);
    chk("R4 active", isr_active_o, 1);
    arch_flg = ~fl; arch_pc = pc ^ 16'h5A5A;
    irq_i = 1'b0;
    go(1'b0, 1'b0, 1'b0, n);
    chk("R9 exit latency", n, lat(2, waits));
    chk("R7 exit pc", arch_pc, pc);
    chk("R7 exit flags", arch_flg, fl);
    chk("R7 exit sp", arch_sp, sp);
    chk("R7 inactive", isr_active_o, 0);
    boundary_i = 1'b0;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, busy_seen;
    logic [DW-1:0] sp0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
    rdy_mode = 1'b0; arst_n = 1'b0;
    start_i = 1'b0; op_ret_i = 1'b0; irq_i = 1'b0; boundary_i = 1'b0;
    arch_pc = 16'h0010; arch_sp = 16'h0080; arch_flg = 5'h00;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 req in reset", mem_req_o, 0);
    chk("R1 strobes in reset", {pc_we_o, sp_we_o, flg_we_o, done_o}, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {busy_o, isr_active_o, mem_req_o, done_o}, 0);

    // directed call and return with ready always high
    do_call(16'h0010, 16'h0080, 16'h0042, 1'b0);
    do_ret(16'h007F, 16'h0011);

    // start held during the sequence is ignored
    do_call(16'h0030, 16'h0060, 16'h00C4, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 no relaunch", busy_o, 0);

    // request without boundary is ignored
    irq_i = 1'b1; boundary_i = 1'b0; busy_seen = 0; sp0 = arch_sp;
    for (int i = 0; i < 6; i++) begin @(negedge clk); busy_seen += busy_o; end
    chk("R5 no entry off boundary", busy_seen, 0);
    chk("R5 sp untouched", arch_sp, sp0);

    // command wins over pending interrupt in the same idle cycle
    boundary_i = 1'b1;
    do_call(16'h0050, 16'h00A0, 16'h0077, 1'b0);
    chk("R10 command first", isr_active_o, 0);
    // interrupt now enters
    sp0 = arch_sp;
    go(1'b0, 1'b0, 1'b0, n);
    chk("R4 entry pc", arch_pc, VEC);
    chk("R4 entry sp", arch_sp, sp0 - 2);
    chk("R4 saved pc", mem[(sp0 - 16'd2) & 16'hFF], 16'h0077);

    // no nesting while active
    busy_seen = 0; sp0 = arch_sp;
    for (int i = 0; i < 8; i++) begin @(negedge clk); busy_seen += busy_o; end
    chk("R6 no second entry", busy_seen, 0);
    chk("R6 sp unchanged", arch_sp, sp0);

    // exit; exit gated by boundary
    irq_i = 1'b0; boundary_i = 1'b0; busy_seen = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); busy_seen += busy_o; end
    chk("R5 no exit off boundary", busy_seen, 0);
    boundary_i = 1'b1;
    go(1'b0, 1'b0, 1'b0, n);
    chk("R7 exit pc", arch_pc, 16'h0077);
    chk("R7 exit sp", arch_sp, sp0 + 2);
    chk("R7 cleared", isr_active_o, 0);
    boundary_i = 1'b0;

    // constrained random with stalls
    rdy_mode = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] rpc, rsp, rw;
      int sel;
      rpc = 16'($urandom % 256);
      rsp = 16'h0020 + 16'($urandom % 192);
      rw  = 16'($urandom);
      sel = $urandom % 3;
      if (sel == 0) do_call(rpc, rsp, rw, 1'b0);
      else if (sel == 1) do_ret(rsp, rw);
      else do_irq(rpc, rsp, 5'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule